// File: doc/BRIEF.md
# Dual-width VM integer ALU

This is the integer execution stage for the arithmetic instructions of a virtual machine with 64-bit registers. Each cycle it takes an 8-bit opcode, the current destination register value, a source register value and a 32-bit immediate. It produces the value to write back and a write strobe, both registered one cycle later.

The low three opcode bits give the instruction class. Class 0x4 runs the operation on 32-bit operands and clears the upper half of the result. Class 0x7 runs the same operation on all 64 bits. Opcode bit 0x08 chooses between the source register and the immediate as the second operand. The high nibble holds the operation code.

Division and modulo are modelled combinationally and are unsigned. Neither one traps. Dividing by zero writes zero. Taking a modulo by zero leaves the destination untouched. Byte swapping belongs to another unit, so its code is refused here.

Top module: `vm_int_alu`

## Requirements
- R1: While `rstN` is low, `result` is 0 and `wrEn` is 0. Reset is asynchronous and takes effect without waiting for a clock edge.
- R2: The `result` and `wrEn` for the inputs present at a rising clock edge appear just after that edge. Before that edge the outputs keep their previous values.
- R3: The class is `opcode[2:0]`. Only 3'h4 (32-bit) and 3'h7 (64-bit) are accepted. For any other class, `wrEn` is 0 and `result` equals `dstVal`.
- R4: For class 3'h4, a written result has bits [63:32] equal to zero. The operation uses only bits [31:0] of each operand.
- R5: If `opcode[3]` is 1, the second operand is `srcVal`. If it is 0, the second operand is the immediate. A 32-bit operation uses `immVal` as it is. A 64-bit operation first sign-extends `immVal` from bit 31.
- R6: The operation is set by `opcode[7:4]`: 0x0 add, 0x1 sub, 0x2 mul (low half of the product), 0x4 or, 0x5 and, 0x8 neg, 0xa xor, 0xb mov. All of them wrap modulo the operand width. Neg gives the two's complement of the destination and ignores the second operand. Mov copies the second operand.
- R7: Code 0x3 is unsigned divide and code 0x9 is unsigned remainder. A divide whose divisor is zero at the operand width writes 0 with `wrEn` = 1.
- R8: A remainder whose divisor is zero at the operand width gives `wrEn` = 0, and `result` equals the full 64-bit `dstVal`.
- R9: Code 0x6 is shift left, 0x7 is logical shift right and 0xc is arithmetic shift right. The shift amount is the second operand masked to 5 bits for 32-bit operations and to 6 bits for 64-bit operations.
- R10: Codes 0xd, 0xe and 0xf are not executed. They give `wrEn` = 0 and `result` = `dstVal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opcode | input | 8 | Operation code, source select bit and class |
| dstVal | input | 64 | Current destination register value |
| srcVal | input | 64 | Source register value |
| immVal | input | 32 | Immediate field |
| result | output | 64 | Registered value to write back |
| wrEn | output | 1 | Registered write strobe for the destination |

## Verification
The bench builds the unit with its default widths: 64-bit registers and a 32-bit immediate. With these widths the lane split lands at bit 32, so the same operand can be run through both lanes and the results compared. The vector set uses this to show the narrow lane discarding a carry that the wide lane keeps, and an immediate that comes out sign-extended in one lane and zero-extended in the other. It also covers shift counts just past each mask limit, and divisors that are zero only in their low half, which makes a 32-bit divide or remainder see a zero divisor.

// File: rtl/vm_int_alu_pkg.sv
package vm_int_alu_pkg;

  // Operation codes carried in opcode[7:4]
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_LSH  = 4'h6,
    OP_RSH  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'ha,
    OP_MOV  = 4'hb,
    OP_ARSH = 4'hc,
    OP_SWAP = 4'hd,
    OP_RSVE = 4'he,
    OP_RSVF = 4'hf
  } aluOp_e;

  localparam logic [2:0] CLS_NARROW = 3'h4;
  localparam logic [2:0] CLS_WIDE   = 3'h7;
  localparam aluOp_e     OP_LAST    = OP_ARSH;

  // Strobes from decode to the datapath
  typedef struct packed {
    logic   legal;
    logic   wide;
    logic   useReg;
    aluOp_e op;
  } aluCtrl_t;

endpackage

// File: rtl/vm_int_alu_decode.sv
module vm_int_alu_decode
  import vm_int_alu_pkg::*;
(
  input  logic [7:0] opcode,
  output aluCtrl_t   ctrl
);
  logic [2:0] cls;
  logic       clsOk;
  logic       codeOk;

  assign cls    = opcode[2:0];
  assign clsOk  = (cls == CLS_NARROW) || (cls == CLS_WIDE);
  assign codeOk = (opcode[7:4] <= OP_LAST);

  always_comb begin
    ctrl.legal  = clsOk && codeOk;
    ctrl.wide   = (cls == CLS_WIDE);
    ctrl.useReg = opcode[3];
    ctrl.op     = aluOp_e'(opcode[7:4]);
  end
endmodule

// File: rtl/vm_int_alu_exec.sv
module vm_int_alu_exec
  import vm_int_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  aluCtrl_t          ctrl,
  input  logic [XLEN-1:0]   dstVal,
  input  logic [XLEN-1:0]   srcVal,
  input  logic [IMMW-1:0]   immVal,
  output logic [XLEN-1:0]   nextRes,
  output logic              nextWr
);
  localparam int HALF  = XLEN / 2;
  localparam int LANES = 2;

  logic [XLEN-1:0] immWide;
  logic [XLEN-1:0] opB;
  logic [XLEN-1:0] laneRes [LANES];
  logic            laneZero [LANES];
  logic            sel;
  logic            modZero;

  assign immWide = {{(XLEN-IMMW){immVal[IMMW-1]}}, immVal};
  assign opB     = ctrl.useReg ? srcVal : immWide;

  // Lane 0 works at half width, lane 1 at full width
  for (genvar g = 0; g < LANES; g++) begin : gLane
    localparam int LW = (g == 0) ? HALF : XLEN;
    localparam int LS = $clog2(LW);

    logic [LW-1:0] a;
    logic [LW-1:0] b;
    logic [LW-1:0] r;
    logic [LS-1:0] sh;
    logic          bZero;

    assign a     = dstVal[LW-1:0];
    assign b     = opB[LW-1:0];
    assign sh    = b[LS-1:0];
    assign bZero = (b == '0);

    always_comb begin
      case (ctrl.op)
        OP_ADD:  r = a + b;
        OP_SUB:  r = a - b;
        OP_MUL:  r = a * b;
        OP_DIV:  r = bZero ? '0 : a / b;
        OP_OR:   r = a | b;
        OP_AND:  r = a & b;
        OP_LSH:  r = a << sh;
        OP_RSH:  r = a >> sh;
        OP_NEG:  r = '0 - a;
        OP_MOD:  r = bZero ? a : a % b;
        OP_XOR:  r = a ^ b;
        OP_MOV:  r = b;
        OP_ARSH: r = $signed(a) >>> sh;
        default: r = a;
      endcase
    end

    assign laneRes[g]  = XLEN'(r);
    assign laneZero[g] = bZero;
  end

  assign sel     = ctrl.wide;
  assign modZero = (ctrl.op == OP_MOD) && laneZero[sel];
  assign nextWr  = ctrl.legal && !modZero;
  assign nextRes = nextWr ? laneRes[sel] : dstVal;
endmodule

// File: rtl/vm_int_alu_retire.sv
module vm_int_alu_retire #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] nextRes,
  input  logic            nextWr,
  output logic [XLEN-1:0] resQ,
  output logic            wrQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ <= '0;
      wrQ  <= 1'b0;
    end else begin
      resQ <= nextRes;
      wrQ  <= nextWr;
    end
  end
endmodule

// File: rtl/vm_int_alu.sv
module vm_int_alu
  import vm_int_alu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      opcode,
  input  logic [XLEN-1:0] dstVal,
  input  logic [XLEN-1:0] srcVal,
  input  logic [IMMW-1:0] immVal,
  output logic [XLEN-1:0] result,
  output logic            wrEn
);
  aluCtrl_t        ctrl;
  logic [XLEN-1:0] nextRes;
  logic            nextWr;

  vm_int_alu_decode u_decode (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  vm_int_alu_exec #(.XLEN(XLEN), .IMMW(IMMW)) u_exec (
    .ctrl    (ctrl),
    .dstVal  (dstVal),
    .srcVal  (srcVal),
    .immVal  (immVal),
    .nextRes (nextRes),
    .nextWr  (nextWr)
  );

  vm_int_alu_retire #(.XLEN(XLEN)) u_retire (
    .clk     (clk),
    .rstN    (rstN),
    .nextRes (nextRes),
    .nextWr  (nextWr),
    .resQ    (result),
    .wrQ     (wrEn)
  );
endmodule

// File: rtl/vm_int_alu_chk.sv
module vm_int_alu_chk #(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [7:0]      opcode,
  input logic [XLEN-1:0] dstVal,
  input logic [XLEN-1:0] srcVal,
  input logic [IMMW-1:0] immVal,
  input logic [XLEN-1:0] result,
  input logic            wrEn
);
  localparam int HALF = XLEN / 2;

  logic            armed;
  logic            isNarrow;
  logic            isWide;
  logic [XLEN-1:0] opB;
  logic            divisorZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign isNarrow    = (opcode[2:0] == 3'h4);
  assign isWide      = (opcode[2:0] == 3'h7);
  assign opB         = opcode[3] ? srcVal : {{(XLEN-IMMW){immVal[IMMW-1]}}, immVal};
  assign divisorZero = isWide ? (opB == '0) : (opB[HALF-1:0] == '0);

  // R3: a foreign class never writes and passes the destination through
  a_r3_class_gate: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(!(isNarrow || isWide)) |-> !wrEn && result == $past(dstVal));

  // R4: narrow results carry a clear upper half
  a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(isNarrow) && wrEn |-> result[XLEN-1:HALF] == '0);

  // R7: divide by zero writes zero
  a_r7_div_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past((isNarrow || isWide) && opcode[7:4] == 4'h3 && divisorZero)
      |-> wrEn && result == '0);

  // R8: remainder by zero keeps the destination
  a_r8_mod_zero_keeps: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past((isNarrow || isWide) && opcode[7:4] == 4'h9 && divisorZero)
      |-> !wrEn && result == $past(dstVal));

  // R9: a wide shift by a masked count of zero is the identity
  a_r9_zero_shift_identity: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past(isWide && opcode[7:4] == 4'h6 && opB[5:0] == 6'd0)
      |-> wrEn && result == $past(dstVal));

  // R10: codes above arithmetic shift are refused
  a_r10_unused_codes: assert property (@(posedge clk) disable iff (!rstN)
    armed && $past((isNarrow || isWide) && opcode[7:4] > 4'hc) |-> !wrEn);
endmodule

bind vm_int_alu vm_int_alu_chk #(.XLEN(XLEN), .IMMW(IMMW)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .opcode (opcode),
  .dstVal (dstVal),
  .srcVal (srcVal),
  .immVal (immVal),
  .result (result),
  .wrEn   (wrEn)
);

// File: tb/vm_int_alu_tb.sv
`timescale 1ns/1ps
module vm_int_alu_tb;
  localparam int XLEN = 64;
  localparam int IMMW = 32;
  localparam int WATCHDOG_NS = 100000;

  typedef struct packed {
    logic [7:0]  op;
    logic [63:0] dst;
    logic [63:0] src;
    logic [31:0] imm;
    logic [63:0] res;
    logic        wr;
  } vec_t;

  localparam int NVEC = 36;
  localparam vec_t VECS [NVEC] = '{
    '{8'h0c, 64'h00000001FFFFFFFF, 64'h0000000500000002, 32'h0,        64'h0000000000000001, 1'b1}, // R4 R6 narrow add wraps
    '{8'h0f, 64'h00000001FFFFFFFF, 64'h0000000500000002, 32'h0,        64'h0000000700000001, 1'b1}, // R6 wide add
    '{8'ha4, 64'hFFFF000012345678, 64'h0,                32'h80000001, 64'h0000000092345679, 1'b1}, // R5 narrow xor imm
    '{8'ha7, 64'hFFFF000012345678, 64'h0,                32'h80000001, 64'h0000FFFF92345679, 1'b1}, // R5 wide xor imm sign-extended
    '{8'h17, 64'h5,                64'h0,                32'h7,        64'hFFFFFFFFFFFFFFFE, 1'b1}, // R6 wide sub
    '{8'h14, 64'h5,                64'h0,                32'h7,        64'h00000000FFFFFFFE, 1'b1}, // R4 narrow sub
    '{8'h2f, 64'h0000000100000000, 64'h3,                32'h0,        64'h0000000300000000, 1'b1}, // R6 wide mul
    '{8'h2c, 64'h0000000100000000, 64'h3,                32'h0,        64'h0,                1'b1}, // R4 narrow mul
    '{8'h3f, 64'd100,              64'd7,                32'h0,        64'd14,               1'b1}, // R7 divide
    '{8'h3f, 64'h1234,             64'h0,                32'h0,        64'h0,                1'b1}, // R7 divide by zero
    '{8'h3c, 64'h1234,             64'h0000000100000000, 32'h0,        64'h0,                1'b1}, // R7 narrow divisor zero
    '{8'h9f, 64'd100,              64'd7,                32'h0,        64'd2,                1'b1}, // R7 remainder
    '{8'h9f, 64'hDEADBEEF00000055, 64'h0,                32'h0,        64'hDEADBEEF00000055, 1'b0}, // R8 remainder by zero
    '{8'h9c, 64'hAAAA000000000011, 64'h0000000500000000, 32'h0,        64'hAAAA000000000011, 1'b0}, // R8 narrow remainder by zero
    '{8'h3f, 64'hFFFFFFFFFFFFFFFF, 64'h2,                32'h0,        64'h7FFFFFFFFFFFFFFF, 1'b1}, // R7 unsigned divide
    '{8'h4f, 64'hF0,               64'h0F,               32'h0,        64'hFF,               1'b1}, // R6 or
    '{8'h57, 64'hFFFFFFFFFFFFFFFF, 64'h0,                32'h0000FF00, 64'hFF00,             1'b1}, // R6 and imm
    '{8'h54, 64'h123456789ABCDEF0, 64'h0,                32'hFFFF0000, 64'h000000009ABC0000, 1'b1}, // R5 narrow and imm
    '{8'h6f, 64'h1,                64'h41,               32'h0,        64'h2,                1'b1}, // R9 wide shift count masked
    '{8'h6c, 64'h1,                64'h21,               32'h0,        64'h2,                1'b1}, // R9 narrow shift count masked
    '{8'h7f, 64'h8000000000000000, 64'd63,               32'h0,        64'h1,                1'b1}, // R9 logical right
    '{8'h74, 64'hFFFFFFFF80000000, 64'h0,                32'd31,       64'h1,                1'b1}, // R9 narrow logical right
    '{8'hcf, 64'h8000000000000000, 64'd4,                32'h0,        64'hF800000000000000, 1'b1}, // R9 arithmetic right
    '{8'hcc, 64'h0000000080000000, 64'd4,                32'h0,        64'h00000000F8000000, 1'b1}, // R9 narrow arithmetic right
    '{8'h87, 64'h1,                64'h55,               32'h77,       64'hFFFFFFFFFFFFFFFF, 1'b1}, // R6 neg ignores operand
    '{8'h84, 64'h1,                64'h55,               32'h77,       64'h00000000FFFFFFFF, 1'b1}, // R6 narrow neg
    '{8'hbf, 64'h0,                64'h123456789ABCDEF0, 32'h0,        64'h123456789ABCDEF0, 1'b1}, // R6 mov reg
    '{8'hb7, 64'h0,                64'h0,                32'hFFFFFFFE, 64'hFFFFFFFFFFFFFFFE, 1'b1}, // R5 wide mov imm
    '{8'hb4, 64'h0,                64'h0,                32'hFFFFFFFE, 64'h00000000FFFFFFFE, 1'b1}, // R5 narrow mov imm
    '{8'hbc, 64'h0,                64'hAAAAAAAA55555555, 32'h0,        64'h0000000055555555, 1'b1}, // R4 narrow mov reg
    '{8'h0d, 64'h77,               64'h1,                32'h1,        64'h77,               1'b0}, // R3 foreign class
    '{8'h0e, 64'h99,               64'h1,                32'h1,        64'h99,               1'b0}, // R3 foreign class
    '{8'hd4, 64'h1122,             64'h0,                32'd16,       64'h1122,             1'b0}, // R10 swap code refused
    '{8'hef, 64'h3344,             64'h1,                32'h0,        64'h3344,             1'b0}, // R10 code e refused
    '{8'h04, 64'h0,                64'h0,                32'h80000000, 64'h0000000080000000, 1'b1}, // R5 narrow add imm
    '{8'h07, 64'h0,                64'h0,                32'h80000000, 64'hFFFFFFFF80000000, 1'b1}  // R5 wide add imm
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [7:0]      opcode = 8'h0;
  logic [XLEN-1:0] dstVal = '0;
  logic [XLEN-1:0] srcVal = '0;
  logic [IMMW-1:0] immVal = '0;
  logic [XLEN-1:0] result;
  logic            wrEn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vm_int_alu #(.XLEN(XLEN), .IMMW(IMMW)) u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .opcode (opcode),
    .dstVal (dstVal),
    .srcVal (srcVal),
    .immVal (immVal),
    .result (result),
    .wrEn   (wrEn)
  );

  task automatic check(input string tag, input logic [63:0] actRes, input logic actWr,
                       input logic [63:0] expRes, input logic expWr);
    checks++;
    if (actRes !== expRes || actWr !== expWr) begin
      errors++;
      $display("FAIL %s: result=%h wrEn=%b expected result=%h wrEn=%b",
               tag, actRes, actWr, expRes, expWr);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                       input logic [31:0] i);
    opcode = op; dstVal = d; srcVal = s; immVal = i;
  endtask

  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    repeat (3) @(negedge clk);
    check("R1 reset state", result, wrEn, 64'h0, 1'b0);
    rstN = 1'b1;

    // R2: outputs change only after the capturing edge
    @(negedge clk);
    drive(8'h0f, 64'd3, 64'd4, 32'h0);
    #1;
    check("R2 before edge", result, wrEn, 64'h0, 1'b0);
    @(negedge clk);
    check("R2 after edge", result, wrEn, 64'd7, 1'b1);

    // Vector table
    for (int k = 0; k < NVEC; k++) begin
      drive(VECS[k].op, VECS[k].dst, VECS[k].src, VECS[k].imm);
      @(negedge clk);
      check($sformatf("vector %0d op %h", k, VECS[k].op), result, wrEn,
            VECS[k].res, VECS[k].wr);
    end

    // R3: every foreign class refuses a write
    for (int c = 0; c < 8; c++) begin
      if (c != 4 && c != 7) begin
        drive({4'h0, 1'b1, 3'(c)}, 64'hABCD0000 + 64'(c), 64'h1, 32'h1);
        @(negedge clk);
        check($sformatf("R3 class %0d", c), result, wrEn, 64'hABCD0000 + 64'(c), 1'b0);
      end
    end

    // R10: code f in the wide class
    drive(8'hf7, 64'h5A5A, 64'h1, 32'h1);
    @(negedge clk);
    check("R10 code f", result, wrEn, 64'h5A5A, 1'b0);

    // R9: wide shift keeps bit 5 of the count, narrow drops it
    drive(8'h6f, 64'h1, 64'd32, 32'h0);
    @(negedge clk);
    check("R9 wide shift 32", result, wrEn, 64'h0000000100000000, 1'b1);
    drive(8'h6c, 64'h1, 64'd32, 32'h0);
    @(negedge clk);
    check("R9 narrow shift 32 masks to 0", result, wrEn, 64'h1, 1'b1);

    // R1: asynchronous reset mid-run clears outputs
    drive(8'h0f, 64'd10, 64'd20, 32'h0);
    @(negedge clk);
    check("R6 add before reset", result, wrEn, 64'd30, 1'b1);
    rstN = 1'b0;
    #1;
    check("R1 async reset", result, wrEn, 64'h0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 recover after reset", result, wrEn, 64'd30, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule